// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block holds two mailbox registers that let two clock domains pass single data words to each other without going through a queue. Mailbox one is loaded from side A and read on side B. Mailbox two is loaded from side B and read on side A. Each side has its own clock, chip select, enable and write/read select. A side-specific select condition marks the access as a mailbox access.

Each mailbox has a "free" flag owned by its writer. The flag goes low on the edge that loads the mailbox. Further loads are refused until the reader has taken the word. A read on the far side is carried back to the writer as a toggle through a synchronizer, so the flag returns high a fixed number of writer edges later. Each read port always presents the contents of the mailbox it reads.

Top module: `dual_clk_mailbox`

## Requirements
- R1: A side-A mailbox access happens on a rising `a_clk` edge with `a_cs_n`=0, `a_en`=1 and `a_mbx_sel`=1. `a_wr`=1 makes it a write of mailbox one and `a_wr`=0 makes it a read of mailbox two.
- R2: A side-B mailbox access needs `b_cs_n`=0, `b_en`=1 and `b_size`=2'b11 on a rising `b_clk` edge. `b_wr`=1 makes it a write of mailbox two and `b_wr`=0 makes it a read of mailbox one. Any other `b_size` value is not a mailbox access.
- R3: A side-A write accepted while `m1_free`=1 stores `a_wdata` in mailbox one and drives `m1_free` low on that same edge.
- R4: While `m1_free`=0, side-A writes are ignored and mailbox one keeps its value.
- R5: A side-B mailbox read made at least two `b_clk` edges after a write returns `m1_free` high on the second `a_clk` rising edge after that read. Before that edge the flag stays low.
- R6: Mailbox two mirrors R3 to R5 with the sides swapped. A side-B write drives `m2_free` low, writes are ignored while it is low, and a side-A read returns it high on the second `b_clk` edge after the read.
- R7: While `rst_n`=0, both flags are high and both mailboxes read as zero. Reset is held for at least four rising edges of each clock.
- R8: `b_rdata` always shows mailbox one and `a_rdata` always shows mailbox two.
- R9: An edge with chip select high or enable low changes neither a mailbox nor a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Side-A clock |
| b_clk | input | 1 | Side-B clock |
| rst_n | input | 1 | Active-low reset, common to both sides |
| a_cs_n | input | 1 | Side-A chip select, active low |
| a_en | input | 1 | Side-A enable, active high |
| a_wr | input | 1 | Side-A direction: 1 write, 0 read |
| a_mbx_sel | input | 1 | Side-A mailbox select |
| a_wdata | input | DATA_W | Side-A write word for mailbox one |
| a_rdata | output | DATA_W | Contents of mailbox two |
| b_cs_n | input | 1 | Side-B chip select, active low |
| b_en | input | 1 | Side-B enable, active high |
| b_wr | input | 1 | Side-B direction: 1 write, 0 read |
| b_size | input | 2 | Side-B size code; 2'b11 selects the mailboxes |
| b_wdata | input | DATA_W | Side-B write word for mailbox two |
| b_rdata | output | DATA_W | Contents of mailbox one |
| m1_free | output | 1 | Mailbox one free flag, side-A domain |
| m2_free | output | 1 | Mailbox two free flag, side-B domain |

## Verification
Random words are written with random chip-select, enable and select combinations. This separates real mailbox accesses from near-misses, since each near-miss must leave both the flag and the data untouched. Directed sequences cover the following cases:
- A second write against a held mailbox, which tells an ignored load apart from an overwrite.
- A side-B read with a non-mailbox size code, which tells the two-bit select apart from a one-bit one.
- The flag, checked just after the far-side read and again two writer edges later, which pins the synchronizer latency in both directions.
- A reset in the middle of the run, with both mailboxes holding data.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   typedef struct packed {
      logic wr;
      logic rd;
   } mbx_strobe_t;

   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   import mbx_pkg::*;

   if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
      $error("mbx_sync: STAGES must be at least %0d", MIN_SYNC_STAGES);
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
   import mbx_pkg::*;
#(
   parameter int unsigned SEL_W = 1
) (
   input  logic             cs_n,
   input  logic             en,
   input  logic             wr,
   input  logic [SEL_W-1:0] sel,
   output mbx_strobe_t      stb
);
   if (SEL_W < 1) begin : g_bad_sel
      $error("mbx_port_dec: SEL_W must be at least 1");
   end

   logic hit;

   // A mailbox is addressed only when every select bit is high.
   assign hit    = !cs_n && en && (&sel);
   assign stb.wr = hit && wr;
   assign stb.rd = hit && !wr;

endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
   parameter int unsigned DATA_W      = 36,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_stb,
   output logic [DATA_W-1:0] data,
   output logic              free
);
   logic wr_tgl, rd_tgl;
   logic wr_tgl_rs, rd_tgl_ws;
   logic accept, pending;

   // Writer domain: the load toggle, and the reader's toggle brought across.
   mbx_sync #(.STAGES(SYNC_STAGES)) u_rd_to_wr (
      .clk(wr_clk), .rst_n(rst_n), .d(rd_tgl), .q(rd_tgl_ws)
   );

   assign free   = (wr_tgl == rd_tgl_ws);
   assign accept = wr_stb && free;

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_tgl <= 1'b0;
         data   <= '0;
      end else if (accept) begin
         wr_tgl <= ~wr_tgl;
         data   <= wdata;
      end
   end

   // Reader domain: a read only counts once the load has been seen here.
   mbx_sync #(.STAGES(SYNC_STAGES)) u_wr_to_rd (
      .clk(rd_clk), .rst_n(rst_n), .d(wr_tgl), .q(wr_tgl_rs)
   );

   assign pending = (wr_tgl_rs != rd_tgl);

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n)                 rd_tgl <= 1'b0;
      else if (rd_stb && pending) rd_tgl <= ~rd_tgl;
   end

   // R3: an accepted load takes the flag low at once
   a_r3_load_holds: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_stb && free) |=> !free);

   // R4: a held mailbox keeps its word on every writer edge
   a_r4_no_overwrite: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !free |=> $stable(data));

   // R5: a counted read ends the pending state in the reader domain
   a_r5_read_consumes: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_stb && pending) |=> !pending);

   // R3: the reader never sees pending data while the writer reports free
   a_r3_pending_not_free: assert property (@(posedge rd_clk) disable iff (!rst_n)
      pending |-> !free);

endmodule

// File: rtl/dual_clk_mailbox.sv
module dual_clk_mailbox
   import mbx_pkg::*;
#(
   parameter int unsigned DATA_W      = 36,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              a_clk,
   input  logic              b_clk,
   input  logic              rst_n,
   input  logic              a_cs_n,
   input  logic              a_en,
   input  logic              a_wr,
   input  logic              a_mbx_sel,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   input  logic              b_cs_n,
   input  logic              b_en,
   input  logic              b_wr,
   input  logic [1:0]        b_size,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata,
   output logic              m1_free,
   output logic              m2_free
);
   localparam int unsigned N_CH = 2;

   if (DATA_W < 1) begin : g_bad_width
      $error("dual_clk_mailbox: DATA_W must be at least 1");
   end

   mbx_strobe_t a_stb, b_stb;

   mbx_port_dec #(.SEL_W(1)) u_dec_a (
      .cs_n(a_cs_n), .en(a_en), .wr(a_wr), .sel(a_mbx_sel), .stb(a_stb)
   );

   mbx_port_dec #(.SEL_W(2)) u_dec_b (
      .cs_n(b_cs_n), .en(b_en), .wr(b_wr), .sel(b_size), .stb(b_stb)
   );

   // Channel 0 carries A to B (mailbox one), channel 1 carries B to A.
   logic [N_CH-1:0]   ch_wclk, ch_rclk, ch_wstb, ch_rstb, ch_free;
   logic [DATA_W-1:0] ch_wdata [N_CH];
   logic [DATA_W-1:0] ch_data  [N_CH];

   assign ch_wclk     = {b_clk, a_clk};
   assign ch_rclk     = {a_clk, b_clk};
   assign ch_wstb     = {b_stb.wr, a_stb.wr};
   assign ch_rstb     = {a_stb.rd, b_stb.rd};
   assign ch_wdata[0] = a_wdata;
   assign ch_wdata[1] = b_wdata;

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      mbx_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ch (
         .wr_clk(ch_wclk[g]), .rd_clk(ch_rclk[g]), .rst_n(rst_n),
         .wr_stb(ch_wstb[g]), .wdata(ch_wdata[g]), .rd_stb(ch_rstb[g]),
         .data(ch_data[g]), .free(ch_free[g])
      );
   end

   assign b_rdata = ch_data[0];
   assign a_rdata = ch_data[1];
   assign m1_free = ch_free[0];
   assign m2_free = ch_free[1];

   // R9: without chip select and enable, side A cannot load mailbox one
   a_r9_idle_a: assert property (@(posedge a_clk) disable iff (!rst_n)
      (a_cs_n || !a_en) |=> $stable(b_rdata));

   // R2: a side-B edge with a non-mailbox size code leaves mailbox two alone
   a_r2_size_gate: assert property (@(posedge b_clk) disable iff (!rst_n)
      (b_size != 2'b11) |=> $stable(a_rdata));

endmodule

// File: tb/tb_dual_clk_mailbox.sv
module tb_dual_clk_mailbox;
   localparam int CLK_PERIOD = 10;
   localparam int B_PERIOD   = 14;
   localparam int DW         = 36;

   logic a_clk = 0, b_clk = 0, rst_n = 0;
   logic a_cs_n = 1, a_en = 0, a_wr = 0, a_mbx_sel = 0;
   logic b_cs_n = 1, b_en = 0, b_wr = 0;
   logic [1:0] b_size = 0;
   logic [DW-1:0] a_wdata = 0, b_wdata = 0;
   logic [DW-1:0] a_rdata, b_rdata;
   logic m1_free, m2_free;

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   logic [DW-1:0] exp_m1, exp_m2;
   bit exp_f1, exp_f2;

   always #(CLK_PERIOD/2) a_clk = ~a_clk;
   always #(B_PERIOD/2)   b_clk = ~b_clk;

   dual_clk_mailbox #(.DATA_W(DW)) dut (.*);

   function automatic bit a_hits(bit cs_n, bit en, bit sel);
      return !cs_n && en && sel;
   endfunction

   function automatic bit b_hits(bit cs_n, bit en, bit [1:0] sz);
      return !cs_n && en && (sz == 2'b11);
   endfunction

   task automatic check(bit ok, string req, logic [63:0] got, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic chk_all(string req);
      check(b_rdata == exp_m1, req, 64'(b_rdata), 64'(exp_m1));
      check(a_rdata == exp_m2, req, 64'(a_rdata), 64'(exp_m2));
      check(m1_free == exp_f1, req, 64'(m1_free), 64'(exp_f1));
      check(m2_free == exp_f2, req, 64'(m2_free), 64'(exp_f2));
   endtask

   task automatic a_op(bit cs_n, bit en, bit wr, bit sel, logic [DW-1:0] d);
      @(negedge a_clk);
      a_cs_n = cs_n; a_en = en; a_wr = wr; a_mbx_sel = sel; a_wdata = d;
      @(posedge a_clk);
      @(negedge a_clk);
      a_cs_n = 1; a_en = 0;
   endtask

   task automatic b_op(bit cs_n, bit en, bit wr, bit [1:0] sz, logic [DW-1:0] d);
      @(negedge b_clk);
      b_cs_n = cs_n; b_en = en; b_wr = wr; b_size = sz; b_wdata = d;
      @(posedge b_clk);
      @(negedge b_clk);
      b_cs_n = 1; b_en = 0;
   endtask

   task automatic wait_a(int n);
      for (int i = 0; i < n; i++) @(posedge a_clk);
      @(negedge a_clk);
   endtask

   task automatic wait_b(int n);
      for (int i = 0; i < n; i++) @(posedge b_clk);
      @(negedge b_clk);
   endtask

   task automatic do_reset();
      rst_n = 0;
      wait_a(5); wait_b(5);
      exp_m1 = 0; exp_m2 = 0; exp_f1 = 1; exp_f2 = 1;
      chk_all("R7 reset");
      @(negedge a_clk); rst_n = 1;
      wait_a(2); wait_b(2);
   endtask

   initial begin
      logic [DW-1:0] d;
      void'($urandom(32'h5eed_1234));
      do_reset();

      // R1 R3: load mailbox one, flag drops on the same edge
      a_op(0, 1, 1, 1, 36'h1_2345_6789);
      exp_m1 = 36'h1_2345_6789; exp_f1 = 0;
      check(m1_free == 0, "R3 flag low", 64'(m1_free), 0);
      check(b_rdata == exp_m1, "R8 b_rdata", 64'(b_rdata), 64'(exp_m1));
      // R4: second load refused
      a_op(0, 1, 1, 1, 36'hA_AAAA_AAAA);
      check(b_rdata == exp_m1, "R4 no overwrite", 64'(b_rdata), 64'(exp_m1));
      wait_b(3);
      // R2: non-mailbox size code does not release
      b_op(0, 1, 0, 2'b01, 0);
      wait_a(3);
      check(m1_free == 0, "R2 size 01 ignored", 64'(m1_free), 0);
      // R9: chip select high does nothing
      b_op(1, 1, 0, 2'b11, 0);
      wait_a(3);
      check(m1_free == 0, "R9 cs high ignored", 64'(m1_free), 0);
      // R5: valid read; still low just after, high two A edges later
      b_op(0, 1, 0, 2'b11, 0);
      check(m1_free == 0, "R5 still low", 64'(m1_free), 0);
      wait_a(2);
      exp_f1 = 1;
      check(m1_free == 1, "R5 released", 64'(m1_free), 1);

      // R6: mailbox two mirror
      b_op(0, 1, 1, 2'b11, 36'h0_BEEF_CAFE);
      exp_m2 = 36'h0_BEEF_CAFE; exp_f2 = 0;
      check(m2_free == 0, "R6 flag low", 64'(m2_free), 0);
      check(a_rdata == exp_m2, "R8 a_rdata", 64'(a_rdata), 64'(exp_m2));
      b_op(0, 1, 1, 2'b11, 36'h5_5555_5555);
      check(a_rdata == exp_m2, "R6 no overwrite", 64'(a_rdata), 64'(exp_m2));
      wait_a(3);
      a_op(0, 0, 0, 1, 0);
      wait_b(3);
      check(m2_free == 0, "R9 en low ignored", 64'(m2_free), 0);
      a_op(0, 1, 0, 1, 0);
      check(m2_free == 0, "R6 still low", 64'(m2_free), 0);
      wait_b(2);
      exp_f2 = 1;
      check(m2_free == 1, "R6 released", 64'(m2_free), 1);
      chk_all("R8 settled");

      // Random accesses, R1 R2 R9
      for (int it = 0; it < 40; it++) begin
         bit cs, en, sl;
         bit [1:0] sz;
         cs = 1'($urandom); en = 1'($urandom); sl = 1'($urandom);
         d = {4'($urandom), 32'($urandom)};
         a_op(cs, en, 1, sl, d);
         if (a_hits(cs, en, sl) && exp_f1) begin exp_m1 = d; exp_f1 = 0; end
         chk_all("R1 random A write");
         if (!exp_f1) begin
            wait_b(3);
            b_op(0, 1, 0, 2'b11, 0);
            wait_a(3);
            exp_f1 = 1;
            chk_all("R5 random release");
         end
         cs = 1'($urandom); en = 1'($urandom); sz = 2'($urandom);
         d = {4'($urandom), 32'($urandom)};
         b_op(cs, en, 1, sz, d);
         if (b_hits(cs, en, sz) && exp_f2) begin exp_m2 = d; exp_f2 = 0; end
         chk_all("R2 random B write");
         if (!exp_f2) begin
            wait_a(3);
            a_op(0, 1, 0, 1, 0);
            wait_b(3);
            exp_f2 = 1;
            chk_all("R6 random release");
         end
      end

      // R7: reset with both mailboxes loaded
      a_op(0, 1, 1, 1, 36'hF_0F0F_0F0F);
      b_op(0, 1, 1, 2'b11, 36'h3_3333_3333);
      do_reset();

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule